// File: doc/BRIEF.md
# Banked Program Counter Controller

This block produces the 12-bit instruction fetch address of a small 8-bit controller whose program store is split into two 2K halves. Each cycle it applies at most one instruction-level strobe (step, jump, call, return, return-from-service) and, when allowed, enters an interrupt service routine by an injected call to a fixed vector. A bank flag, set and cleared by its own strobes, supplies address bit 11 for jumps and calls. Sequential stepping never touches bit 11.

The return-address stack lives outside the block. The controller asks for a push through `push_o` and `push_addr_o` in the same cycle as the call or interrupt entry. A return takes the restored address from `pop_addr_i`. Interrupt requests are single-cycle pulses that are latched as pending. A pending request is accepted only when no service routine is active and the current strobe is not a call or a return. While a routine is active, jumps and calls are forced into bank 0. The bank flag itself is kept, and it applies again once return-from-service clears the in-service state.

Top module: `pc_bank_ctrl`

## Requirements
- R1: While `rst_ni` is low, and at the first clock after reset, `pc_o` is 000h, `in_service_o` is 0, `push_o` is 0 and the bank flag is cleared, so a later jump lands in bank 0.
- R2: `inc_i` adds one to bits 10:0 and keeps bit 11: 7FFh steps to 000h and FFFh steps to 800h.
- R3: `jmp_i` loads `{bank_flag, target_i}` into `pc_o` at the next clock edge.
- R4: `call_i` loads the same address as a jump and, in the same cycle, raises `push_o` with `push_addr_o` equal to `pc_o` stepped as in R2.
- R5: `ret_i` and `retr_i` load all 12 bits of `pop_addr_i` into `pc_o`. Only `retr_i` clears the in-service state.
- R6: A request pulse is latched at one edge. At the next edge it is accepted unless the active strobe is a call or a return. On acceptance `pc_o` becomes 003h for the external request or 007h for the timer request, whatever the current bank. In the accepting cycle `push_o` is 1 and `push_addr_o` holds the address the instruction would have loaded.
- R7: While `in_service_o` is 1, jumps and calls load bit 11 as 0. After `retr_i` the bank flag applies again, unchanged.
- R8: When a request is accepted in the same cycle as a jump to bank 1, `push_addr_o` carries the full jump target with bit 11 set.
- R9: `in_service_o` stays 1 until `retr_i`. Requests that arrive during service stay pending and are not lost. When both requests are pending, the external one is taken first.
- R10: `bank_set_i` sets the bank flag and `bank_clr_i` clears it, with clear winning when both are high. The new value applies from the next cycle.
- R11: With no strobe active and no interrupt accepted, `pc_o` holds its value.
- R12: When several instruction strobes are high at once, the first in the order retr, ret, call, jmp, inc takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Sequential step strobe |
| jmp_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Plain return strobe |
| retr_i | input | 1 | Return from service routine strobe |
| target_i | input | 11 | Jump or call target, bits 10:0 |
| bank_set_i | input | 1 | Set bank flag |
| bank_clr_i | input | 1 | Clear bank flag |
| irq_ext_i | input | 1 | External interrupt request pulse |
| irq_tmr_i | input | 1 | Timer interrupt request pulse |
| pop_addr_i | input | 12 | Address restored from the return stack |
| pc_o | output | 12 | Fetch address |
| push_o | output | 1 | Push request to the return stack |
| push_addr_o | output | 12 | Address to push |
| in_service_o | output | 1 | Service routine active |

## Verification
A bit 11 that follows the carry, or a bank flag that leaks into service mode, shows on `pc_o` one edge after the step or jump that exposes it. A lost or reordered pending request shows only after the next `retr_i`, as a missing or wrong vector. For that reason the bench queues a timer request during service and checks the vector after the return. A pushed address that is wrong appears on `push_addr_o` in the same cycle, before the edge, so the bench samples it then.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_INC,
    OP_JMP,
    OP_CALL,
    OP_RET,
    OP_RETR
  } pc_op_e;

  // fixed priority: retr > ret > call > jmp > inc
  function automatic pc_op_e decode_op(input logic inc, input logic jmp,
                                       input logic call, input logic ret,
                                       input logic retr);
    if (retr)      return OP_RETR;
    else if (ret)  return OP_RET;
    else if (call) return OP_CALL;
    else if (jmp)  return OP_JMP;
    else if (inc)  return OP_INC;
    else           return OP_IDLE;
  endfunction

endpackage

// File: rtl/pcb_bank_flag.sv
module pcb_bank_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end

  AST_BANK_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_o); // R10
  AST_BANK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> flag_o); // R10

endmodule

// File: rtl/pcb_irq_ctrl.sv
module pcb_irq_ctrl #(
  parameter int ADDR_W  = 12,
  parameter int EXT_VEC = 3,
  parameter int TMR_VEC = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_req_i,
  input  logic              tmr_req_i,
  input  logic              retr_i,
  input  logic              block_i,
  output logic              accept_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic              in_service_o
);

  logic pend_ext_q, pend_tmr_q, isr_q;
  logic take_ext, take_tmr;

  assign accept_o = (pend_ext_q || pend_tmr_q) && !isr_q && !block_i;
  assign take_ext = accept_o && pend_ext_q;
  assign take_tmr = accept_o && !pend_ext_q;
  assign vec_o    = pend_ext_q ? ADDR_W'(EXT_VEC) : ADDR_W'(TMR_VEC);
  assign in_service_o = isr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_ext_q <= 1'b0;
      pend_tmr_q <= 1'b0;
      isr_q      <= 1'b0;
    end else begin
      pend_ext_q <= (pend_ext_q && !take_ext) || ext_req_i;
      pend_tmr_q <= (pend_tmr_q && !take_tmr) || tmr_req_i;
      if (accept_o)    isr_q <= 1'b1;
      else if (retr_i) isr_q <= 1'b0;
    end
  end

  AST_ISR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_q && !retr_i) |=> isr_q); // R9
  AST_ISR_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> isr_q); // R6
  AST_NO_NESTING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_q |-> !accept_o); // R9
  AST_PEND_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_tmr_q && isr_q) |=> pend_tmr_q); // R9

endmodule

// File: rtl/pcb_next_addr.sv
module pcb_next_addr
  import pcb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  pc_op_e            op_i,
  input  logic [ADDR_W-2:0] target_i,
  input  logic              bank_i,
  input  logic [ADDR_W-1:0] pop_addr_i,
  output logic [ADDR_W-1:0] step_o,
  output logic [ADDR_W-1:0] seq_o
);

  localparam int LOW_W = ADDR_W - 1;

  // bit 11 (top bit) never takes the carry
  assign seq_o = {pc_i[ADDR_W-1], pc_i[LOW_W-1:0] + LOW_W'(1)};

  always_comb begin
    unique case (op_i)
      OP_INC:          step_o = seq_o;
      OP_JMP, OP_CALL: step_o = {bank_i, target_i};
      OP_RET, OP_RETR: step_o = pop_addr_i;
      default:         step_o = pc_i;
    endcase
  end

endmodule

// File: rtl/pc_bank_ctrl.sv
module pc_bank_ctrl
  import pcb_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int EXT_VEC = 3,
  parameter int TMR_VEC = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              jmp_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              retr_i,
  input  logic [ADDR_W-2:0] target_i,
  input  logic              bank_set_i,
  input  logic              bank_clr_i,
  input  logic              irq_ext_i,
  input  logic              irq_tmr_i,
  input  logic [ADDR_W-1:0] pop_addr_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              push_o,
  output logic [ADDR_W-1:0] push_addr_o,
  output logic              in_service_o
);

  localparam int BANK_BIT = ADDR_W - 1;

  pc_op_e            op;
  logic              bank_flag, bank_eff, block, accept;
  logic [ADDR_W-1:0] vec, step_addr, seq_addr, pc_q;

  assign op    = decode_op(inc_i, jmp_i, call_i, ret_i, retr_i);
  assign block = (op == OP_CALL) || (op == OP_RET) || (op == OP_RETR);

  pcb_bank_flag i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (bank_set_i),
    .clr_i  (bank_clr_i),
    .flag_o (bank_flag)
  );

  pcb_irq_ctrl #(
    .ADDR_W  (ADDR_W),
    .EXT_VEC (EXT_VEC),
    .TMR_VEC (TMR_VEC)
  ) i_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ext_req_i    (irq_ext_i),
    .tmr_req_i    (irq_tmr_i),
    .retr_i       (op == OP_RETR),
    .block_i      (block),
    .accept_o     (accept),
    .vec_o        (vec),
    .in_service_o (in_service_o)
  );

  // service routine locks jumps and calls into bank 0
  assign bank_eff = bank_flag && !in_service_o;

  pcb_next_addr #(.ADDR_W(ADDR_W)) i_next (
    .pc_i       (pc_q),
    .op_i       (op),
    .target_i   (target_i),
    .bank_i     (bank_eff),
    .pop_addr_i (pop_addr_i),
    .step_o     (step_addr),
    .seq_o      (seq_addr)
  );

  // injected call saves the full address the instruction resolves to
  assign push_o      = accept || (op == OP_CALL);
  assign push_addr_o = accept ? step_addr : seq_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (accept) pc_q <= vec;
    else             pc_q <= step_addr;
  end

  assign pc_o = pc_q;

  AST_INC_KEEPS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_INC && !accept) |=> pc_q[BANK_BIT] == $past(pc_q[BANK_BIT])); // R2
  AST_JMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_JMP && !accept && !in_service_o)
      |=> pc_q == {$past(bank_flag), $past(target_i)}); // R3
  AST_CALL_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_CALL) |-> push_o); // R4
  AST_RET_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RET || op == OP_RETR) |=> pc_q == $past(pop_addr_i)); // R5
  AST_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (pc_q == ADDR_W'(EXT_VEC) || pc_q == ADDR_W'(TMR_VEC))); // R6
  AST_ISR_BANK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_service_o && (op == OP_JMP || op == OP_CALL)) |=> !pc_q[BANK_BIT]); // R7
  AST_IRQ_JMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op == OP_JMP) |-> push_addr_o == {bank_flag, target_i}); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_IDLE && !accept) |=> $stable(pc_q)); // R11

endmodule

// File: tb/test_pc_bank_ctrl.sv
`timescale 1ns/1ps
module test_pc_bank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc = 0, jmp = 0, call = 0, ret = 0, retr = 0;
  logic [10:0] tgt = '0;
  logic        bset = 0, bclr = 0, iext = 0, itmr = 0;
  logic [11:0] pop = '0;
  logic [11:0] pc, push_addr;
  logic        push, insvc;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  pc_bank_ctrl i_pc_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .inc_i(inc), .jmp_i(jmp), .call_i(call),
    .ret_i(ret), .retr_i(retr), .target_i(tgt), .bank_set_i(bset),
    .bank_clr_i(bclr), .irq_ext_i(iext), .irq_tmr_i(itmr),
    .pop_addr_i(pop), .pc_o(pc), .push_o(push), .push_addr_o(push_addr),
    .in_service_o(insvc)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %03h expected %03h", req, act, exp);
    end
  endtask

  // op: 0 idle 1 inc 2 jmp 3 call 4 ret 5 retr 6 bank set 7 bank clr
  task automatic drive(input int op, input logic [10:0] t);
    inc = (op == 1); jmp = (op == 2); call = (op == 3);
    ret = (op == 4); retr = (op == 5); bset = (op == 6); bclr = (op == 7);
    tgt = t;
    #1;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    inc = 0; jmp = 0; call = 0; ret = 0; retr = 0; bset = 0; bclr = 0;
    iext = 0; itmr = 0;
  endtask

  // {op, target, expected pc after edge}
  localparam logic [25:0] VEC [15] = '{
    {3'd1, 11'h000, 12'h001},  // R2
    {3'd2, 11'h7FF, 12'h7FF},  // R3
    {3'd1, 11'h000, 12'h000},  // R2 wrap low bank
    {3'd0, 11'h000, 12'h000},  // R11
    {3'd2, 11'h123, 12'h123},  // R3
    {3'd1, 11'h000, 12'h124},  // R2
    {3'd4, 11'h000, 12'hFFF},  // R5
    {3'd1, 11'h000, 12'h800},  // R2 wrap high bank
    {3'd1, 11'h000, 12'h801},  // R2
    {3'd2, 11'h055, 12'h055},  // R3
    {3'd6, 11'h000, 12'h055},  // R10
    {3'd2, 11'h3FF, 12'hBFF},  // R3 R10
    {3'd1, 11'h000, 12'hC00},  // R2
    {3'd7, 11'h000, 12'hC00},  // R10
    {3'd2, 11'h010, 12'h010}   // R10
  };

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 pc in reset", pc, 12'h000);
    chk("R1 in_service in reset", {11'b0, insvc}, 12'h000);
    rst_n = 1'b1;
    tick;
    chk("R1 pc after reset", pc, 12'h000);
    chk("R1 push after reset", {11'b0, push}, 12'h000);

    pop = 12'hFFF;
    for (int i = 0; i < 15; i++) begin
      drive(int'(VEC[i][25:23]), VEC[i][22:12]);
      tick;
      chk($sformatf("R2/R3/R5/R10/R11 vector %0d", i), pc, VEC[i][11:0]);
    end

    // R4 call pushes the stepped address
    drive(6, 0); tick;
    drive(2, 11'h100); tick;
    chk("R3 jmp bank1", pc, 12'h900);
    drive(3, 11'h200);
    chk("R4 push strobe", {11'b0, push}, 12'h001);
    chk("R4 push address", push_addr, 12'h901);
    tick;
    chk("R4 call target", pc, 12'hA00);

    // R6 external vector from bank 1
    iext = 1; drive(0, 0); tick;
    drive(0, 0);
    chk("R6 push on entry", {11'b0, push}, 12'h001);
    chk("R6 pushed address", push_addr, 12'hA00);
    tick;
    chk("R6 ext vector", pc, 12'h003);
    chk("R6 in_service set", {11'b0, insvc}, 12'h001);

    // R7 bank 0 lock in service
    drive(2, 11'h400); tick;
    chk("R7 jmp in service", pc, 12'h400);
    drive(3, 11'h010);
    chk("R7 call push address", push_addr, 12'h401);
    tick;
    chk("R7 call in service", pc, 12'h010);

    // R9 timer held pending during service
    itmr = 1; drive(0, 0); tick;
    drive(0, 0); tick;
    drive(0, 0); tick;
    chk("R9 no nested entry", pc, 12'h010);
    pop = 12'h055; drive(4, 0); tick;
    chk("R5 ret restores", pc, 12'h055);
    chk("R9 plain ret keeps service", {11'b0, insvc}, 12'h001);
    pop = 12'hA00; drive(5, 0); tick;
    chk("R5 retr restores", pc, 12'hA00);
    chk("R5 retr clears service", {11'b0, insvc}, 12'h000);
    drive(0, 0);
    chk("R9 pending timer pushes", push_addr, 12'hA00);
    tick;
    chk("R6 timer vector", pc, 12'h007);
    drive(5, 0); tick;
    drive(2, 11'h300); tick;
    chk("R7 flag applies after retr", pc, 12'hB00);

    // R8 interrupt accepted on a bank-1 jump
    iext = 1; drive(0, 0); tick;
    drive(2, 11'h7AB);
    chk("R8 pushed target bit 11", push_addr, 12'hFAB);
    tick;
    chk("R8 vector after jump", pc, 12'h003);
    pop = 12'hFAB; drive(5, 0); tick;
    chk("R8 return to target", pc, 12'hFAB);

    // R9 ext before timer
    iext = 1; itmr = 1; drive(0, 0); tick;
    drive(0, 0); tick;
    chk("R9 ext first", pc, 12'h003);
    pop = 12'h000; drive(5, 0); tick;
    drive(0, 0); tick;
    chk("R9 timer second", pc, 12'h007);
    drive(5, 0); tick;

    // R12 priority: retr beats call
    pop = 12'h123;
    drive(3, 11'h044); retr = 1; #1;
    chk("R12 no push on retr+call", {11'b0, push}, 12'h000);
    tick;
    chk("R12 retr wins", pc, 12'h123);

    // R10 clear wins over set
    drive(6, 0); bclr = 1; tick;
    drive(2, 11'h001); tick;
    chk("R10 clr wins", pc, 12'h001);

    // R1 reset mid-run clears flag and service
    drive(6, 0); tick;
    iext = 1; drive(0, 0); tick;
    drive(0, 0); tick;
    rst_n = 0; #1;
    chk("R1 async reset pc", pc, 12'h000);
    chk("R1 async reset service", {11'b0, insvc}, 12'h000);
    tick;
    rst_n = 1; tick;
    drive(2, 11'h222); tick;
    chk("R1 flag cleared by reset", pc, 12'h222);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule